// File: doc/BRIEF.md
# Status-Bit Completion Poller

This block runs on the host side of a flash memory. After the host has finished writing a program or erase command sequence, it pulses a start request with the operation type, a target address and, for a program operation, the word that was written. The block first waits a fixed settle interval. It then repeatedly reads the most significant data bit through a simple synchronous read port, and watches for the value that marks the end of the internal operation.

For a program operation, the end is reached when the top bit returns the true value of the written word's top bit rather than its inverse. For an erase operation, the end is reached when the top bit reads 1. Reads go to the program address itself, or to the base of the sector being erased, found by clearing the low `SECT_BITS` of the target address. A matching status read is never taken as final data, because the lower bits may still be settling. The block therefore issues one confirming read and returns that word.

The block pulses `done` once, for a single cycle. An error flag reports when the poll budget runs out. A second flag reports when a program operation's confirmed word differs from the written word. Both flags stay valid until the next start.

Top module: `dpoll_checker`

## Requirements
- R1: For a program operation, a status read counts as complete when `memRdData[DW-1]` equals `expData[DW-1]`; a read with the inverted bit continues polling.
- R2: For an erase operation, a status read counts as complete when `memRdData[DW-1]` is 1; a 0 continues polling, and `expData` is not used.
- R3: Every read of a program operation drives `memAddr` equal to `tgtAddr`. Every read of an erase operation drives `tgtAddr` with its low `SECT_BITS` bits forced to 0.
- R4: `startReq` is accepted in a cycle where `busy` is low. The first read (`memRdEn` high) occurs exactly `SETTLE_CYCLES+1` cycles after that cycle, and no read occurs before it.
- R5: After a completing status read, exactly one more read is issued. `resultData` equals the data returned by that confirming read, not the data of the completing status read.
- R6: `done` is high for exactly one cycle, in the cycle after the last read's data is returned. In that cycle `busy` is low and `memRdEn` is low.
- R7: If `MAX_POLLS` consecutive status reads all show "in progress", no further read is issued and `done` pulses with `timeoutErr` set. Completion on read number `MAX_POLLS` still succeeds.
- R8: For a program operation, `dataErr` is set with `done` when the confirmed word differs from `expData`. It is never set for an erase operation.
- R9: While reset (`rstN` low) is applied, `busy`, `done`, `memRdEn`, `timeoutErr` and `dataErr` are all 0.
- R10: `startReq` has no effect while `busy` is high. The operation's addresses, read count and result are unchanged.
- R11: An accepted start clears `timeoutErr` and `dataErr` from the previous operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start polling; sampled when idle |
| opErase | input | 1 | 1 = erase operation, 0 = program operation |
| tgtAddr | input | AW | Program address, or any address inside the erased sector |
| expData | input | DW | Word that was programmed |
| memRdEn | output | 1 | Read strobe; data returns on the next cycle |
| memAddr | output | AW | Read address |
| memRdData | input | DW | Read data, valid the cycle after `memRdEn` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| resultData | output | DW | Word from the confirming read |
| timeoutErr | output | 1 | Poll budget exhausted |
| dataErr | output | 1 | Program result differs from expected word |

## Verification
The poller is driven by a memory model that returns a chosen number of "in progress" status reads. It then returns one completing read whose lower bits are still wrong, and finally the settled word. Program operations use both values of the written top bit, which tells a true comparison apart from a fixed polarity. Erase operations use an unaligned address, which exposes a missing sector mask. The busy count is set to zero, to `MAX_POLLS-1` and to `MAX_POLLS` or more, which separates an immediate match, a last-chance match and a timeout. A wrong confirmed program word and a stray start mid-operation show the error flag and the ignore rule.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_POLL_RD,
    ST_POLL_CHK,
    ST_CONF_RD,
    ST_CONF_CHK
  } pollState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // latch operation inputs, clear flags
    logic cntClr;      // clear shared counter
    logic cntInc;      // advance shared counter
    logic rdEn;        // issue a read
    logic capture;     // take confirming read word
    logic flagTimeout; // poll budget exhausted
  } ctrlStrobe_t;

endpackage

// File: rtl/dpoll_datapath.sv
module dpoll_datapath
  import dpoll_pkg::*;
#(
  parameter int AW            = 16,
  parameter int DW            = 8,
  parameter int SECT_BITS     = 8,
  parameter int MAX_POLLS     = 16,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic          opErase,
  input  logic [AW-1:0] tgtAddr,
  input  logic [DW-1:0] expData,
  input  logic [DW-1:0] memRdData,
  output logic [AW-1:0] memAddr,
  output logic          statusMatch,
  output logic          settleDone,
  output logic          lastPoll,
  output logic [DW-1:0] resultData,
  output logic          timeoutErr,
  output logic          dataErr
);

  localparam int CNT_MAX = (MAX_POLLS > SETTLE_CYCLES) ? MAX_POLLS : SETTLE_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int STAT_B  = DW - 1;
  localparam logic [CNT_W-1:0] LAST_POLL  = CNT_W'(MAX_POLLS - 1);
  localparam logic [CNT_W-1:0] LAST_SETTL = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [AW-1:0]    SECT_MASK  = ~((AW'(1) << SECT_BITS) - AW'(1));

  logic [AW-1:0]    addrQ;
  logic [DW-1:0]    expQ;
  logic             eraseQ;
  logic [CNT_W-1:0] cntQ;
  logic [DW-1:0]    resultQ;
  logic             timeoutQ;
  logic             dataErrQ;
  logic [AW-1:0]    addrSel;

  // erase polls the sector base, program polls the exact address
  generate
    if (SECT_BITS > 0) begin : g_mask
      assign addrSel = opErase ? (tgtAddr & SECT_MASK) : tgtAddr;
    end else begin : g_nomask
      assign addrSel = tgtAddr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      expQ   <= '0;
      eraseQ <= 1'b0;
    end else if (strobe.load) begin
      addrQ  <= addrSel;
      expQ   <= expData;
      eraseQ <= opErase;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              cntQ <= '0;
    else if (strobe.cntClr) cntQ <= '0;
    else if (strobe.cntInc) cntQ <= cntQ + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ  <= '0;
      timeoutQ <= 1'b0;
      dataErrQ <= 1'b0;
    end else if (strobe.load) begin
      timeoutQ <= 1'b0;
      dataErrQ <= 1'b0;
    end else begin
      if (strobe.flagTimeout) timeoutQ <= 1'b1;
      if (strobe.capture) begin
        resultQ <= memRdData;
        if (!eraseQ && (memRdData != expQ)) dataErrQ <= 1'b1;
      end
    end
  end

  always_comb begin
    if (eraseQ) statusMatch = memRdData[STAT_B];
    else        statusMatch = (memRdData[STAT_B] == expQ[STAT_B]);
  end

  assign settleDone = (cntQ == LAST_SETTL);
  assign lastPoll   = (cntQ == LAST_POLL);
  assign memAddr    = addrQ;
  assign resultData = resultQ;
  assign timeoutErr = timeoutQ;
  assign dataErr    = dataErrQ;

endmodule

// File: rtl/dpoll_control.sv
module dpoll_control
  import dpoll_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        statusMatch,
  input  logic        settleDone,
  input  logic        lastPoll,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  pollState_t stateQ, stateNxt;
  logic       doneNxt;
  logic       doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateNxt;
      doneQ  <= doneNxt;
    end
  end

  always_comb begin
    stateNxt = stateQ;
    doneNxt  = 1'b0;
    strobe   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startReq) begin
          strobe.load   = 1'b1;
          strobe.cntClr = 1'b1;
          stateNxt      = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (settleDone) begin
          strobe.cntClr = 1'b1;
          stateNxt      = ST_POLL_RD;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_POLL_RD: begin
        strobe.rdEn = 1'b1;
        stateNxt    = ST_POLL_CHK;
      end
      ST_POLL_CHK: begin
        if (statusMatch) begin
          stateNxt = ST_CONF_RD;
        end else if (lastPoll) begin
          strobe.flagTimeout = 1'b1;
          doneNxt            = 1'b1;
          stateNxt           = ST_IDLE;
        end else begin
          strobe.cntInc = 1'b1;
          stateNxt      = ST_POLL_RD;
        end
      end
      ST_CONF_RD: begin
        strobe.rdEn = 1'b1;
        stateNxt    = ST_CONF_CHK;
      end
      ST_CONF_CHK: begin
        strobe.capture = 1'b1;
        doneNxt        = 1'b1;
        stateNxt       = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = doneQ;

endmodule

// File: rtl/dpoll_checker.sv
module dpoll_checker
  import dpoll_pkg::*;
#(
  parameter int AW            = 16,
  parameter int DW            = 8,
  parameter int SECT_BITS     = 8,
  parameter int MAX_POLLS     = 16,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic          opErase,
  input  logic [AW-1:0] tgtAddr,
  input  logic [DW-1:0] expData,
  output logic          memRdEn,
  output logic [AW-1:0] memAddr,
  input  logic [DW-1:0] memRdData,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] resultData,
  output logic          timeoutErr,
  output logic          dataErr
);

  ctrlStrobe_t strobe;
  logic        statusMatch;
  logic        settleDone;
  logic        lastPoll;

  dpoll_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .statusMatch(statusMatch),
    .settleDone (settleDone),
    .lastPoll   (lastPoll),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done)
  );

  dpoll_datapath #(
    .AW           (AW),
    .DW           (DW),
    .SECT_BITS    (SECT_BITS),
    .MAX_POLLS    (MAX_POLLS),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opErase    (opErase),
    .tgtAddr    (tgtAddr),
    .expData    (expData),
    .memRdData  (memRdData),
    .memAddr    (memAddr),
    .statusMatch(statusMatch),
    .settleDone (settleDone),
    .lastPoll   (lastPoll),
    .resultData (resultData),
    .timeoutErr (timeoutErr),
    .dataErr    (dataErr)
  );

  assign memRdEn = strobe.rdEn;

endmodule

// File: rtl/dpoll_checker_sva.sv
module dpoll_checker_sva #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          memRdEn,
  input logic [AW-1:0] memAddr,
  input logic          busy,
  input logic          done,
  input logic          timeoutErr,
  input logic          dataErr
);

  // R4: reads only happen inside an accepted operation
  p_read_only_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> busy);

  // R6: completion pulse lasts one cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: no read and not busy while done is shown
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!memRdEn && !busy));

  // R7: timeout flag appears together with the completion pulse
  p_timeout_with_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> done);

  // R8: data error appears together with the completion pulse
  p_dataerr_with_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataErr) |-> done);

  // R10: read address cannot move during an operation
  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memAddr));

  // R9: reset state of control outputs
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rstN |=> (!busy && !done && !memRdEn) || !rstN);

endmodule

bind dpoll_checker dpoll_checker_sva #(.AW(AW)) u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .memRdEn   (memRdEn),
  .memAddr   (memAddr),
  .busy      (busy),
  .done      (done),
  .timeoutErr(timeoutErr),
  .dataErr   (dataErr)
);

// File: tb/dpoll_checker_tb.sv
module dpoll_checker_tb;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam int SECT_BITS = 8;
  localparam int MAX_POLLS = 16;
  localparam int SETTLE_CYCLES = 3;

  typedef struct packed {
    logic          op;      // 1 = erase
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [7:0]    busyRd;  // status reads showing "in progress"
    logic [DW-1:0] fin;     // settled word
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h1234, 8'hA5, 8'd3,  8'hA5},
    '{1'b0, 16'h00FF, 8'h3C, 8'd0,  8'h3C},
    '{1'b1, 16'h56C7, 8'h00, 8'd5,  8'hFF},
    '{1'b1, 16'hABCD, 8'h00, 8'd0,  8'hFF},
    '{1'b0, 16'h4000, 8'h81, 8'd15, 8'h81},
    '{1'b0, 16'h7777, 8'h5A, 8'd16, 8'h5A},
    '{1'b0, 16'h2222, 8'hC3, 8'd2,  8'hC1},
    '{1'b1, 16'h9999, 8'h00, 8'd20, 8'hFF},
    '{1'b1, 16'h1000, 8'h00, 8'd1,  8'hEF}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic          opErase = 1'b0;
  logic [AW-1:0] tgtAddr = '0;
  logic [DW-1:0] expData = '0;
  logic          memRdEn;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memRdData;
  logic          busy, done, timeoutErr, dataErr;
  logic [DW-1:0] resultData;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // memory model state
  logic          curOp = 1'b0;
  logic [DW-1:0] curData = '0;
  int            curBusy = 0;
  logic [DW-1:0] curFin = '0;
  logic [AW-1:0] curAddr = '0;
  int            rdIdx = 0;
  int            addrBad = 0;

  dpoll_checker #(
    .AW(AW), .DW(DW), .SECT_BITS(SECT_BITS),
    .MAX_POLLS(MAX_POLLS), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opErase(opErase),
    .tgtAddr(tgtAddr), .expData(expData), .memRdEn(memRdEn),
    .memAddr(memAddr), .memRdData(memRdData), .busy(busy), .done(done),
    .resultData(resultData), .timeoutErr(timeoutErr), .dataErr(dataErr)
  );

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] respond(int idx);
    logic doneBit;
    doneBit = curOp ? 1'b1 : curData[DW-1];
    if (idx < curBusy)       return {~doneBit, ~curFin[DW-2:0]};
    else if (idx == curBusy) return {doneBit, ~curFin[DW-2:0]};
    else                     return curFin;
  endfunction

  initial memRdData = '0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memRdEn) begin
      memRdData <= respond(rdIdx);
      if (memAddr != curAddr) addrBad <= addrBad + 1;
      rdIdx <= rdIdx + 1;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // runs one operation; optional stray start at a given cycle offset
  task automatic run_op(input vec_t v, input int strayAt);
    int k;
    int expReads;
    logic expTo, expErr;
    @(negedge clk);
    curOp = v.op; curData = v.data; curBusy = int'(v.busyRd); curFin = v.fin;
    curAddr = v.op ? {v.addr[AW-1:SECT_BITS], SECT_BITS'(0)} : v.addr;
    rdIdx = 0; addrBad = 0;
    opErase = v.op; tgtAddr = v.addr; expData = v.data; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(!timeoutErr && !dataErr && busy, "R11 flags cleared on start",
          int'({timeoutErr, dataErr, busy}), 1);
    k = 1;
    while (!memRdEn && k < 100) begin
      if (k == strayAt) begin
        startReq = 1'b1; tgtAddr = ~v.addr; opErase = ~v.op; expData = ~v.data;
      end
      @(negedge clk);
      startReq = 1'b0;
      k++;
    end
    check(k == SETTLE_CYCLES + 1, "R4 first read delay", k, SETTLE_CYCLES + 1);
    k = 0;
    while (!done && k < 200) begin
      if (strayAt > 0 && k == 4) startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
      k++;
    end
    expTo    = (int'(v.busyRd) >= MAX_POLLS);
    expReads = expTo ? MAX_POLLS : int'(v.busyRd) + 2;
    expErr   = !expTo && !v.op && (v.fin != v.data);
    check(done && !busy && !memRdEn, "R6 done with idle port", int'(done), 1);
    check(rdIdx == expReads, expTo ? "R7 read count on timeout" : "R5 read count",
          rdIdx, expReads);
    check(addrBad == 0, v.op ? "R3 erase sector address" : "R3 program address",
          addrBad, 0);
    check(timeoutErr == expTo, "R7 timeout flag", int'(timeoutErr), int'(expTo));
    check(dataErr == expErr, "R8 data error flag", int'(dataErr), int'(expErr));
    if (!expTo)
      check(resultData == v.fin, v.op ? "R2 R5 erase result" : "R1 R5 program result",
            int'(resultData), int'(v.fin));
    @(negedge clk);
    check(!done, "R6 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    check(rdIdx == expReads, "R7 no reads after finish", rdIdx, expReads);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({busy, done, memRdEn, timeoutErr, dataErr} == 5'b0, "R9 reset state",
          int'({busy, done, memRdEn, timeoutErr, dataErr}), 0);
    startReq = 1'b1;
    @(negedge clk);
    check(!busy && !memRdEn, "R9 start ignored in reset", int'(busy), 0);
    startReq = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_op(VECS[i], 0);

    // R10: stray starts during settle and polling are ignored
    run_op('{1'b0, 16'h3456, 8'h12, 8'd4, 8'h12}, 2);
    run_op('{1'b1, 16'hC0DE, 8'h00, 8'd6, 8'hFF}, 1);

    finish_run();
  end

  initial begin
    wait (cycles > 100000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    finish_run();
  end

endmodule